// File: doc/BRIEF.md
# Banked Belief Memory with Delta Write-Back

This block holds the running belief sum of every variable node of a quasi-cyclic LDPC decoder. The storage is split into NUM_BANKS independent banks. Each word of a bank holds one circulant-sized vector of LIFT signed elements. The code is built so that two variable nodes that share a check node are never placed in the same bank. One read and one write per bank per cycle is therefore always enough to serve a check node of any degree up to NUM_BANKS.

On the read side, each bank delivers one vector cyclically rotated by a per-edge shift, one cycle after the request. On the write side, a processing unit returns a narrow delta vector, meaning the new sum minus the old one. The block rotates the delta back into the stored alignment and adds it to the stored word with saturation. A word never moves and is never overwritten by a result. Updates from check nodes that overlap in a pipeline all accumulate, whatever order they arrive in.

Before decoding, a load port writes the channel beliefs word by word. Deltas are ignored while a load is in progress.

Top module: `bv_mem`

## Requirements
- R1: While rst_ni is low, every rd_valid_o bit is 0 and rd_data_o is all zeros.
- R2: With load_en_i high, the word at load_addr_i in bank load_bank_i is replaced by load_data_i. Element j of any vector sits at bits [j*W +: W], where W is the element width. Bank b's slice of a per-bank bus sits at [b*width +: width].
- R3: A read with rd_en_i[b] high raises rd_valid_o[b] one cycle later. In that cycle, output element j equals stored element (j+s) mod LIFT, where s = rd_shift_i slice b (0 to LIFT-1). Banks are independent.
- R4: A write with wr_en_i[b] high adds delta element j, as a DELTA_W-bit two's-complement value, to stored element (j+s) mod LIFT of word wr_addr_i. Here s is wr_shift_i slice b. The rotation is the reverse of the read rotation.
- R5: Each element sum saturates to [-2^(BELIEF_W-1), 2^(BELIEF_W-1)-1] and never wraps.
- R6: While load_en_i is high, wr_en_i has no effect on any bank.
- R7: A read of the address being written or loaded in the same cycle returns the value after that write.
- R8: Deltas to the same word in consecutive cycles all accumulate, with none lost.
- R9: A write or load changes only its own word; every other word keeps its value.
- R10: While rd_en_i[b] is low, rd_valid_o[b] is 0 in the next cycle and bank b's rd_data_o slice holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Initial-load strobe; blocks all deltas |
| load_bank_i | input | BANK_W | Bank written by the load |
| load_addr_i | input | ADDR_W | Word address of the load |
| load_data_i | input | LIFT*BELIEF_W | Channel belief vector |
| rd_en_i | input | NUM_BANKS | Per-bank read request |
| rd_addr_i | input | NUM_BANKS*ADDR_W | Per-bank read address |
| rd_shift_i | input | NUM_BANKS*SHIFT_W | Per-bank read rotation |
| rd_data_o | output | NUM_BANKS*LIFT*BELIEF_W | Rotated belief vectors |
| rd_valid_o | output | NUM_BANKS | Read data valid |
| wr_en_i | input | NUM_BANKS | Per-bank delta write |
| wr_addr_i | input | NUM_BANKS*ADDR_W | Per-bank write address |
| wr_shift_i | input | NUM_BANKS*SHIFT_W | Shift used when the word was read |
| wr_delta_i | input | NUM_BANKS*LIFT*DELTA_W | Delta vectors |

## Verification
The bench targets several corner cases, each with a distinct symptom when the design gets it wrong:

- **Rotation direction.** A rotator turned the wrong way produces element mismatches under non-zero shifts.
- **Saturation.** Elements driven past both rails would show wrapped values such as -128 turning into +127.
- **Same-cycle read and write to one address.** A design without forwarding returns the stale word.
- **Deltas in consecutive cycles to one word.** A read-modify-write that loses one update leaves the sum short.
- **Deltas offered during the load.** A design that fails to block them corrupts the channel beliefs found on readback.
- **Untouched words.** A full readback after random traffic catches stray writes to wrong addresses.

// File: rtl/bv_pkg.sv
`timescale 1ns/1ps
package bv_pkg;
  typedef enum logic {
    ROT_FWD = 1'b0,  // out[j] = in[(j+s) mod LIFT]
    ROT_REV = 1'b1   // out[j] = in[(j-s) mod LIFT]
  } rot_dir_e;
endpackage

// File: rtl/bv_rotator.sv
`timescale 1ns/1ps
module bv_rotator
  import bv_pkg::*;
#(
  parameter int       LIFT    = 18,
  parameter int       ELEM_W  = 8,
  parameter rot_dir_e DIR     = ROT_FWD,
  localparam int      SHIFT_W = $clog2(LIFT),
  localparam int      VEC_W   = LIFT * ELEM_W
) (
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [VEC_W-1:0]   vec_o
);

  generate
    if (DIR == ROT_FWD) begin : g_fwd
      always_comb begin
        vec_o = vec_i;
        for (int k = 0; k < LIFT; k++) begin
          if (shift_i == SHIFT_W'(k)) begin
            for (int j = 0; j < LIFT; j++) begin
              vec_o[j*ELEM_W +: ELEM_W] = vec_i[((j + k) % LIFT)*ELEM_W +: ELEM_W];
            end
          end
        end
      end
    end else begin : g_rev
      always_comb begin
        vec_o = vec_i;
        for (int k = 0; k < LIFT; k++) begin
          if (shift_i == SHIFT_W'(k)) begin
            for (int j = 0; j < LIFT; j++) begin
              vec_o[j*ELEM_W +: ELEM_W] = vec_i[((j + LIFT - k) % LIFT)*ELEM_W +: ELEM_W];
            end
          end
        end
      end
    end
  endgenerate

  // a permutation of elements keeps the number of set bits
  always_comb begin
    p_rot_keeps_bits_r3: assert ($countones(vec_o) == $countones(vec_i));
  end

endmodule

// File: rtl/bv_sat_add.sv
`timescale 1ns/1ps
module bv_sat_add #(
  parameter int  LIFT     = 18,
  parameter int  BELIEF_W = 8,
  parameter int  DELTA_W  = 5,
  localparam int EXT_W    = BELIEF_W + 1 - DELTA_W
) (
  input  logic [LIFT*BELIEF_W-1:0] base_i,
  input  logic [LIFT*DELTA_W-1:0]  delta_i,
  output logic [LIFT*BELIEF_W-1:0] sum_o
);

  localparam logic signed [BELIEF_W:0] MAX_V = (BELIEF_W+1)'((1 << (BELIEF_W-1)) - 1);
  localparam logic signed [BELIEF_W:0] MIN_V = -MAX_V - (BELIEF_W+1)'(1);

  genvar j;
  generate
    for (j = 0; j < LIFT; j++) begin : g_elem
      logic [BELIEF_W-1:0]      b;
      logic [DELTA_W-1:0]       d;
      logic signed [BELIEF_W:0] wide;
      logic [BELIEF_W-1:0]      s;

      assign b    = base_i[j*BELIEF_W +: BELIEF_W];
      assign d    = delta_i[j*DELTA_W +: DELTA_W];
      assign wide = $signed({b[BELIEF_W-1], b}) + $signed({{EXT_W{d[DELTA_W-1]}}, d});

      always_comb begin
        if (wide > MAX_V)      s = MAX_V[BELIEF_W-1:0];
        else if (wide < MIN_V) s = MIN_V[BELIEF_W-1:0];
        else                   s = wide[BELIEF_W-1:0];
        p_no_wrap_up_r5: assert (!(!b[BELIEF_W-1] && !d[DELTA_W-1] && s[BELIEF_W-1]));
        p_no_wrap_dn_r5: assert (!(b[BELIEF_W-1] && d[DELTA_W-1] && !s[BELIEF_W-1]));
      end

      assign sum_o[j*BELIEF_W +: BELIEF_W] = s;
    end
  endgenerate

endmodule

// File: rtl/bv_bank.sv
`timescale 1ns/1ps
module bv_bank
  import bv_pkg::*;
#(
  parameter int  LIFT     = 18,
  parameter int  DEPTH    = 8,
  parameter int  BELIEF_W = 8,
  parameter int  DELTA_W  = 5,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int SHIFT_W  = $clog2(LIFT),
  localparam int WORD_W   = LIFT * BELIEF_W,
  localparam int DVEC_W   = LIFT * DELTA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_hit_i,
  input  logic [ADDR_W-1:0]  load_addr_i,
  input  logic [WORD_W-1:0]  load_data_i,
  input  logic               wr_go_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [SHIFT_W-1:0] wr_shift_i,
  input  logic [DVEC_W-1:0]  wr_delta_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [SHIFT_W-1:0] rd_shift_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               rd_valid_o
);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [DVEC_W-1:0] delta_al;
  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] sum_word;
  logic [WORD_W-1:0] rd_raw;
  logic [WORD_W-1:0] rd_rot;

  bv_rotator #(.LIFT(LIFT), .ELEM_W(DELTA_W), .DIR(ROT_REV)) u_wr_rot (
    .vec_i(wr_delta_i), .shift_i(wr_shift_i), .vec_o(delta_al)
  );

  assign old_word = mem_q[wr_addr_i];

  bv_sat_add #(.LIFT(LIFT), .BELIEF_W(BELIEF_W), .DELTA_W(DELTA_W)) u_add (
    .base_i(old_word), .delta_i(delta_al), .sum_o(sum_word)
  );

  always_ff @(posedge clk_i) begin
    if (load_hit_i)   mem_q[load_addr_i] <= load_data_i;
    else if (wr_go_i) mem_q[wr_addr_i]   <= sum_word;
  end

  // forward the value being committed this cycle
  always_comb begin
    if (load_hit_i && load_addr_i == rd_addr_i)  rd_raw = load_data_i;
    else if (wr_go_i && wr_addr_i == rd_addr_i)  rd_raw = sum_word;
    else                                         rd_raw = mem_q[rd_addr_i];
  end

  bv_rotator #(.LIFT(LIFT), .ELEM_W(BELIEF_W), .DIR(ROT_FWD)) u_rd_rot (
    .vec_i(rd_raw), .shift_i(rd_shift_i), .vec_o(rd_rot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_rot;
    end
  end

  genvar w;
  generate
    for (w = 0; w < DEPTH; w++) begin : g_home
      p_fixed_home_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(load_hit_i && load_addr_i == ADDR_W'(w)) && !(wr_go_i && wr_addr_i == ADDR_W'(w)))
        |=> $stable(mem_q[w]));
    end
  endgenerate

  p_valid_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_en_i));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/bv_mem.sv
`timescale 1ns/1ps
module bv_mem #(
  parameter int  NUM_BANKS = 4,
  parameter int  LIFT      = 18,
  parameter int  DEPTH     = 8,
  parameter int  BELIEF_W  = 8,
  parameter int  DELTA_W   = 5,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int SHIFT_W   = $clog2(LIFT),
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WORD_W    = LIFT * BELIEF_W,
  localparam int DVEC_W    = LIFT * DELTA_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_en_i,
  input  logic [BANK_W-1:0]              load_bank_i,
  input  logic [ADDR_W-1:0]              load_addr_i,
  input  logic [WORD_W-1:0]              load_data_i,
  input  logic [NUM_BANKS-1:0]           rd_en_i,
  input  logic [NUM_BANKS*ADDR_W-1:0]    rd_addr_i,
  input  logic [NUM_BANKS*SHIFT_W-1:0]   rd_shift_i,
  output logic [NUM_BANKS*WORD_W-1:0]    rd_data_o,
  output logic [NUM_BANKS-1:0]           rd_valid_o,
  input  logic [NUM_BANKS-1:0]           wr_en_i,
  input  logic [NUM_BANKS*ADDR_W-1:0]    wr_addr_i,
  input  logic [NUM_BANKS*SHIFT_W-1:0]   wr_shift_i,
  input  logic [NUM_BANKS*DVEC_W-1:0]    wr_delta_i
);

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic load_hit;
      logic wr_go;

      assign load_hit = load_en_i && (load_bank_i == BANK_W'(b));
      assign wr_go    = wr_en_i[b] && !load_en_i;

      bv_bank #(
        .LIFT(LIFT), .DEPTH(DEPTH), .BELIEF_W(BELIEF_W), .DELTA_W(DELTA_W)
      ) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_hit_i (load_hit),
        .load_addr_i(load_addr_i),
        .load_data_i(load_data_i),
        .wr_go_i    (wr_go),
        .wr_addr_i  (wr_addr_i[b*ADDR_W +: ADDR_W]),
        .wr_shift_i (wr_shift_i[b*SHIFT_W +: SHIFT_W]),
        .wr_delta_i (wr_delta_i[b*DVEC_W +: DVEC_W]),
        .rd_en_i    (rd_en_i[b]),
        .rd_addr_i  (rd_addr_i[b*ADDR_W +: ADDR_W]),
        .rd_shift_i (rd_shift_i[b*SHIFT_W +: SHIFT_W]),
        .rd_data_o  (rd_data_o[b*WORD_W +: WORD_W]),
        .rd_valid_o (rd_valid_o[b])
      );
    end
  endgenerate

endmodule

// File: tb/bv_mem_test.sv
`timescale 1ns/1ps
module bv_mem_test;
  localparam int K = 4, Z = 18, D = 8, BW = 8, DW = 5;
  localparam int AW = 3, SW = 5, BKW = 2;
  localparam int MAXV = 127, MINV = -128;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_en_i;
  logic [BKW-1:0] load_bank_i;
  logic [AW-1:0] load_addr_i;
  logic [Z*BW-1:0] load_data_i;
  logic [K-1:0] rd_en_i;
  logic [K*AW-1:0] rd_addr_i;
  logic [K*SW-1:0] rd_shift_i;
  logic [K*Z*BW-1:0] rd_data_o;
  logic [K-1:0] rd_valid_o;
  logic [K-1:0] wr_en_i;
  logic [K*AW-1:0] wr_addr_i;
  logic [K*SW-1:0] wr_shift_i;
  logic [K*Z*DW-1:0] wr_delta_i;

  bv_mem #(.NUM_BANKS(K), .LIFT(Z), .DEPTH(D), .BELIEF_W(BW), .DELTA_W(DW)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  int ref_m [K][D][Z];
  logic [Z*BW-1:0] exp_data [K];
  logic exp_valid [K];
  int n_tests = 0, n_fail = 0;
  string tag = "R1";

  task automatic model_step();
    for (int b = 0; b < K; b++) begin
      if (load_en_i && load_bank_i == BKW'(b)) begin
        for (int p = 0; p < Z; p++) ref_m[b][load_addr_i][p] = $signed(load_data_i[p*BW +: BW]);
      end else if (wr_en_i[b] && !load_en_i) begin
        int s, a;
        s = int'(wr_shift_i[b*SW +: SW]);
        a = int'(wr_addr_i[b*AW +: AW]);
        for (int p = 0; p < Z; p++) begin
          int j, d, v;
          j = (p - s + Z) % Z;
          d = $signed(wr_delta_i[(b*Z + j)*DW +: DW]);
          v = ref_m[b][a][p] + d;
          if (v > MAXV) v = MAXV;
          if (v < MINV) v = MINV;
          ref_m[b][a][p] = v;
        end
      end
      exp_valid[b] = rd_en_i[b];
      if (rd_en_i[b]) begin
        int s, a;
        s = int'(rd_shift_i[b*SW +: SW]);
        a = int'(rd_addr_i[b*AW +: AW]);
        for (int j = 0; j < Z; j++) exp_data[b][j*BW +: BW] = BW'(ref_m[b][a][(j + s) % Z]);
      end
    end
  endtask

  task automatic compare();
    for (int b = 0; b < K; b++) begin
      n_tests++;
      if (rd_valid_o[b] !== exp_valid[b] || rd_data_o[b*Z*BW +: Z*BW] !== exp_data[b]) begin
        n_fail++;
        $display("FAIL %s bank %0d: valid %0b data %h, expected valid %0b data %h", tag, b,
                 rd_valid_o[b], rd_data_o[b*Z*BW +: Z*BW], exp_valid[b], exp_data[b]);
      end
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle();
    load_en_i = 0; rd_en_i = '0; wr_en_i = '0;
  endtask

  task automatic rand_delta(int b);
    for (int j = 0; j < Z; j++) wr_delta_i[(b*Z + j)*DW +: DW] = DW'($urandom);
  endtask

  task automatic rand_traffic(bit rd, bit wr);
    for (int b = 0; b < K; b++) begin
      rd_en_i[b] = rd & $urandom_range(0, 1);
      rd_addr_i[b*AW +: AW] = AW'($urandom_range(0, D-1));
      rd_shift_i[b*SW +: SW] = SW'($urandom_range(0, Z-1));
      wr_en_i[b] = wr & $urandom_range(0, 1);
      wr_addr_i[b*AW +: AW] = AW'($urandom_range(0, D-1));
      wr_shift_i[b*SW +: SW] = SW'($urandom_range(0, Z-1));
      rand_delta(b);
    end
  endtask

  task automatic readback(bit shifted);
    for (int a = 0; a < D; a++) begin
      idle();
      for (int b = 0; b < K; b++) begin
        rd_en_i[b] = 1;
        rd_addr_i[b*AW +: AW] = AW'(a);
        rd_shift_i[b*SW +: SW] = shifted ? SW'($urandom_range(0, Z-1)) : '0;
      end
      tick();
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    load_bank_i = '0; load_addr_i = '0; load_data_i = '0;
    rd_addr_i = '0; rd_shift_i = '0; wr_addr_i = '0; wr_shift_i = '0; wr_delta_i = '0;
    for (int b = 0; b < K; b++) begin exp_data[b] = '0; exp_valid[b] = 0; end
    repeat (3) @(negedge clk_i);
    tag = "R1";
    compare();
    rst_ni = 1;

    // load every word while deltas are offered
    tag = "R2 R6";
    for (int b = 0; b < K; b++)
      for (int a = 0; a < D; a++) begin
        rand_traffic(0, 1);
        load_en_i = 1; load_bank_i = BKW'(b); load_addr_i = AW'(a);
        for (int j = 0; j < Z; j++) load_data_i[j*BW +: BW] = BW'($urandom_range(0, 200) - 100);
        tick();
      end
    tag = "R2 R6";
    readback(0);

    tag = "R3";
    repeat (40) begin idle(); rand_traffic(1, 0); tick(); end

    tag = "R10";
    repeat (5) begin idle(); rand_traffic(0, 0); tick(); end

    // saturation at both rails
    tag = "R5";
    idle(); load_en_i = 1; load_bank_i = 0; load_addr_i = 0;
    for (int j = 0; j < Z; j++) load_data_i[j*BW +: BW] = 8'd120;
    tick();
    idle(); load_en_i = 1; load_bank_i = 1; load_addr_i = 0;
    for (int j = 0; j < Z; j++) load_data_i[j*BW +: BW] = 8'h88;
    tick();
    idle();
    wr_en_i = 4'b0011;
    for (int b = 0; b < 2; b++) begin
      wr_addr_i[b*AW +: AW] = '0;
      wr_shift_i[b*SW +: SW] = SW'(3 + b);
      for (int j = 0; j < Z; j++) wr_delta_i[(b*Z + j)*DW +: DW] = (b == 0) ? 5'b01111 : 5'b10000;
    end
    tick();
    idle();
    rd_en_i = 4'b0011; rd_addr_i = '0; rd_shift_i = '0;
    tick();

    // same-cycle write/load and read of one address
    tag = "R7";
    repeat (10) begin
      idle(); rand_traffic(0, 0);
      for (int b = 0; b < K; b++) begin
        wr_en_i[b] = 1; rd_en_i[b] = 1;
        rd_addr_i[b*AW +: AW] = wr_addr_i[b*AW +: AW];
      end
      tick();
    end
    idle(); load_en_i = 1; load_bank_i = 2; load_addr_i = 5;
    for (int j = 0; j < Z; j++) load_data_i[j*BW +: BW] = BW'(j * 3);
    rd_en_i = 4'b0100; rd_addr_i[2*AW +: AW] = 5; rd_shift_i[2*SW +: SW] = 7;
    tick();

    // consecutive deltas to one word
    tag = "R8";
    for (int c = 0; c < 6; c++) begin
      idle();
      wr_en_i[0] = 1; wr_addr_i[0 +: AW] = 2; wr_shift_i[0 +: SW] = SW'(c);
      for (int j = 0; j < Z; j++) wr_delta_i[j*DW +: DW] = DW'(c + 1);
      rd_en_i[0] = 1; rd_addr_i[0 +: AW] = 2; rd_shift_i[0 +: SW] = 0;
      tick();
    end

    tag = "R4 R9";
    repeat (300) begin idle(); rand_traffic(1, 1); tick(); end
    tag = "R9";
    readback(1);

    idle(); tick();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule